// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns the raw bytes at the current program counter of a small 32-bit register machine into decoded fields. The fetch stage hands it a six-byte window read from byte-addressed instruction memory, together with the address of the window's first byte. The first byte alone decides the instruction's format. Its upper nibble gives the instruction class and its lower nibble the function code. The format fixes the length (1, 2, 5 or 6 bytes), whether a register byte follows, and where a 32-bit constant sits in the window.

The outputs are the two register specifiers, the constant, the length, the address of the next sequential instruction and a flag for encodings the machine does not define. Register numbers 0 to 7 name the eight general registers and the value 8 means "no register". Constants are stored least significant byte first, at any byte alignment.

The decode logic is purely combinational. The parameter `OUT_REG` (default 1) adds one register stage on all outputs, with a synchronous active-high reset. When `OUT_REG` is 0 the outputs follow the inputs in the same cycle.

Top module: `vlx_decoder`

## Requirements
- R1: Window byte k occupies `win_i[8k+7:8k]`. The class output equals bits 7:4 of byte 0 and the function output equals bits 3:0 of byte 0.
- R2: The length output for a legal instruction depends on the class alone: 1 for classes 0x0 (idle) and 0x1 (stop), 2 for 0x2 (register copy) and 0x6 (arithmetic), 5 for 0x7 (branch), and 6 for 0x3 (load immediate), 0x4 (store) and 0x5 (load).
- R3: For legal classes 0x2 to 0x6, the first register output equals the high nibble of byte 1 and the second register output equals the low nibble of byte 1.
- R4: For legal classes 0x0, 0x1 and 0x7, both register outputs are 8.
- R5: For legal classes 0x3, 0x4 and 0x5, the constant is bytes 2 to 5 read least significant byte first, so the bytes cd ab 00 00 give 0x0000abcd.
- R6: For a legal branch (class 0x7), the constant is bytes 1 to 4 read least significant byte first.
- R7: For legal classes 0x0, 0x1, 0x2 and 0x6, the constant output is zero.
- R8: The next-address output equals the input address plus the length output, modulo 2^32.
- R9: The illegal flag is 1 exactly when one of these holds: the class is above 0x7; the class is 0x6 and the function is above 3; the class is 0x7 and the function is above 6; or the class is 0x0 to 0x5 and the function is nonzero.
- R10: While the illegal flag is 1, the length is 1, both register outputs are 8 and the constant is zero. The class and function outputs still show byte 0.
- R11: With `OUT_REG`=1, the outputs show the decode of the inputs present at the previous rising clock edge. A clock edge with `rst_i` high sets both register outputs to 8 and every other output to zero.
- R12: For the load-immediate class, the high nibble of byte 1 is passed to the first register output unchanged, even when it is not 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_i | input | 1 | Synchronous active-high reset |
| win_i | input | 48 | Six fetched bytes, byte 0 in the low bits |
| pc_i | input | 32 | Address of byte 0 |
| icode_o | output | 4 | Instruction class |
| ifun_o | output | 4 | Function code |
| reg_a_o | output | 4 | First register specifier, 8 if none |
| reg_b_o | output | 4 | Second register specifier, 8 if none |
| imm_o | output | 32 | Decoded constant, zero if none |
| len_o | output | 3 | Instruction length in bytes |
| pc_next_o | output | 32 | Address of the next sequential instruction |
| illegal_o | output | 1 | Undefined encoding |

## Verification
The assertions assume that the window and the address are stable from one rising edge to the next. The checker compares the outputs with the inputs sampled at the previous edge, so it also assumes the first sampled edge after reset carries real inputs. The bench changes its inputs only on falling edges and holds each vector for a full cycle. It sweeps all 256 first-byte values under three patterns of trailing bytes and addresses, and one of those patterns places the address just below the 32-bit wrap point.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

    localparam int BYTE_W    = 8;
    localparam int NIB_W     = 4;
    localparam int WORD_W    = 32;
    localparam int WIN_BYTES = 6;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int LEN_W     = 3;
    localparam int IMM_BYTES = WORD_W / BYTE_W;

    localparam logic [NIB_W-1:0] REG_NONE       = 4'h8;
    localparam logic [NIB_W-1:0] FUN_MAX_ARITH  = 4'd3;
    localparam logic [NIB_W-1:0] FUN_MAX_BRANCH = 4'd6;

    typedef enum logic [NIB_W-1:0] {
        CLS_IDLE   = 4'h0,
        CLS_STOP   = 4'h1,
        CLS_COPY   = 4'h2,
        CLS_LOADI  = 4'h3,
        CLS_STORE  = 4'h4,
        CLS_LOAD   = 4'h5,
        CLS_ARITH  = 4'h6,
        CLS_BRANCH = 4'h7
    } opcls_e;

    typedef enum logic [1:0] {
        IMM_NONE  = 2'd0,
        IMM_AT_B1 = 2'd1,
        IMM_AT_B2 = 2'd2
    } imm_src_e;

    typedef struct packed {
        logic             has_regs;
        imm_src_e         imm_src;
        logic [LEN_W-1:0] len;
        logic             bad;
    } fmt_t;

    typedef struct packed {
        logic [NIB_W-1:0]  icode;
        logic [NIB_W-1:0]  ifun;
        logic [NIB_W-1:0]  reg_a;
        logic [NIB_W-1:0]  reg_b;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
        logic              bad;
    } dec_t;

    function automatic fmt_t fmt_of(logic [NIB_W-1:0] code, logic [NIB_W-1:0] fun);
        fmt_t f;
        f.has_regs = 1'b0;
        f.imm_src  = IMM_NONE;
        f.len      = 3'd1;
        f.bad      = 1'b0;
        case (code)
            CLS_IDLE, CLS_STOP: begin
                f.bad = (fun != '0);
            end
            CLS_COPY: begin
                f.has_regs = 1'b1;
                f.len      = 3'd2;
                f.bad      = (fun != '0);
            end
            CLS_LOADI, CLS_STORE, CLS_LOAD: begin
                f.has_regs = 1'b1;
                f.imm_src  = IMM_AT_B2;
                f.len      = 3'd6;
                f.bad      = (fun != '0);
            end
            CLS_ARITH: begin
                f.has_regs = 1'b1;
                f.len      = 3'd2;
                f.bad      = (fun > FUN_MAX_ARITH);
            end
            CLS_BRANCH: begin
                f.imm_src  = IMM_AT_B1;
                f.len      = 3'd5;
                f.bad      = (fun > FUN_MAX_BRANCH);
            end
            default: begin
                f.bad = 1'b1;
            end
        endcase
        if (f.bad) begin
            f.has_regs = 1'b0;
            f.imm_src  = IMM_NONE;
            f.len      = 3'd1;
        end
        return f;
    endfunction

endpackage

// File: rtl/vlx_format_lookup.sv
module vlx_format_lookup
    import vlx_pkg::*;
(
    input  logic [BYTE_W-1:0] head_i,
    output logic [NIB_W-1:0]  icode_o,
    output logic [NIB_W-1:0]  ifun_o,
    output fmt_t              fmt_o
);

    always_comb begin
        icode_o = head_i[BYTE_W-1:NIB_W];
        ifun_o  = head_i[NIB_W-1:0];
        fmt_o   = fmt_of(icode_o, ifun_o);
    end

endmodule

// File: rtl/vlx_field_extract.sv
module vlx_field_extract
    import vlx_pkg::*;
#(
    parameter int TAIL_BYTES = WIN_BYTES - 1,
    localparam int TAIL_W    = TAIL_BYTES * BYTE_W
) (
    input  logic [TAIL_W-1:0] tail_i,
    input  fmt_t              fmt_i,
    output logic [NIB_W-1:0]  reg_a_o,
    output logic [NIB_W-1:0]  reg_b_o,
    output logic [WORD_W-1:0] imm_o
);

    // tail byte j is window byte j+1
    logic [BYTE_W-1:0] tb [TAIL_BYTES];
    logic [WORD_W-1:0] imm_b1;
    logic [WORD_W-1:0] imm_b2;

    for (genvar j = 0; j < TAIL_BYTES; j++) begin : g_unpack
        assign tb[j] = tail_i[j*BYTE_W +: BYTE_W];
    end

    // least significant byte sits at the lowest address
    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_le
        assign imm_b1[k*BYTE_W +: BYTE_W] = tb[k];
        assign imm_b2[k*BYTE_W +: BYTE_W] = tb[k+1];
    end

    always_comb begin
        if (fmt_i.has_regs) begin
            reg_a_o = tb[0][BYTE_W-1:NIB_W];
            reg_b_o = tb[0][NIB_W-1:0];
        end else begin
            reg_a_o = REG_NONE;
            reg_b_o = REG_NONE;
        end
        case (fmt_i.imm_src)
            IMM_AT_B1: imm_o = imm_b1;
            IMM_AT_B2: imm_o = imm_b2;
            default:   imm_o = '0;
        endcase
    end

endmodule

// File: rtl/vlx_pc_step.sv
module vlx_pc_step
    import vlx_pkg::*;
#(
    parameter int ADDR_W = WORD_W
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] pc_next_o
);

    always_comb begin
        pc_next_o = pc_i + ADDR_W'(len_i);
    end

endmodule

// File: rtl/vlx_decoder.sv
module vlx_decoder
    import vlx_pkg::*;
#(
    parameter int ADDR_W  = WORD_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [WIN_W-1:0]    win_i,
    input  logic [ADDR_W-1:0]   pc_i,
    output logic [NIB_W-1:0]    icode_o,
    output logic [NIB_W-1:0]    ifun_o,
    output logic [NIB_W-1:0]    reg_a_o,
    output logic [NIB_W-1:0]    reg_b_o,
    output logic [WORD_W-1:0]   imm_o,
    output logic [LEN_W-1:0]    len_o,
    output logic [ADDR_W-1:0]   pc_next_o,
    output logic                illegal_o
);

    fmt_t              fmt;
    dec_t              dec_c;
    dec_t              dec_o;
    logic [ADDR_W-1:0] pc_next_c;
    logic [ADDR_W-1:0] pc_next_q;

    vlx_format_lookup u_fmt (
        .head_i  (win_i[BYTE_W-1:0]),
        .icode_o (dec_c.icode),
        .ifun_o  (dec_c.ifun),
        .fmt_o   (fmt)
    );

    vlx_field_extract #(
        .TAIL_BYTES (WIN_BYTES - 1)
    ) u_fields (
        .tail_i  (win_i[WIN_W-1:BYTE_W]),
        .fmt_i   (fmt),
        .reg_a_o (dec_c.reg_a),
        .reg_b_o (dec_c.reg_b),
        .imm_o   (dec_c.imm)
    );

    assign dec_c.len = fmt.len;
    assign dec_c.bad = fmt.bad;

    vlx_pc_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .pc_i      (pc_i),
        .len_i     (fmt.len),
        .pc_next_o (pc_next_c)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                dec_o.icode <= '0;
                dec_o.ifun  <= '0;
                dec_o.reg_a <= REG_NONE;
                dec_o.reg_b <= REG_NONE;
                dec_o.imm   <= '0;
                dec_o.len   <= '0;
                dec_o.bad   <= 1'b0;
                pc_next_q   <= '0;
            end else begin
                dec_o     <= dec_c;
                pc_next_q <= pc_next_c;
            end
        end
    end else begin : g_comb
        assign dec_o     = dec_c;
        assign pc_next_q = pc_next_c;
    end

    assign icode_o   = dec_o.icode;
    assign ifun_o    = dec_o.ifun;
    assign reg_a_o   = dec_o.reg_a;
    assign reg_b_o   = dec_o.reg_b;
    assign imm_o     = dec_o.imm;
    assign len_o     = dec_o.len;
    assign illegal_o = dec_o.bad;
    assign pc_next_o = pc_next_q;

endmodule

// File: rtl/vlx_decoder_chk.sv
module vlx_decoder_chk
    import vlx_pkg::*;
#(
    parameter int ADDR_W  = WORD_W,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [WIN_W-1:0]  win_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [NIB_W-1:0]  icode_o,
    input logic [NIB_W-1:0]  ifun_o,
    input logic [NIB_W-1:0]  reg_a_o,
    input logic [NIB_W-1:0]  reg_b_o,
    input logic [WORD_W-1:0] imm_o,
    input logic [LEN_W-1:0]  len_o,
    input logic [ADDR_W-1:0] pc_next_o,
    input logic              illegal_o
);

    logic [WIN_W-1:0]  win_q;
    logic [ADDR_W-1:0] pc_q;
    logic              primed;

    if (OUT_REG) begin : g_dly
        always_ff @(posedge clk_i) begin
            win_q  <= win_i;
            pc_q   <= pc_i;
            primed <= !rst_i;
        end
    end else begin : g_now
        assign win_q  = win_i;
        assign pc_q   = pc_i;
        assign primed = 1'b1;
    end

    assert_opcode_split_R1: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        (icode_o == win_q[7:4]) && (ifun_o == win_q[3:0]));

    assert_len_set_R2: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        (len_o == 3'd1) || (len_o == 3'd2) || (len_o == 3'd5) || (len_o == 3'd6));

    assert_regs_byte1_R3: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        (!illegal_o && (len_o == 3'd2 || len_o == 3'd6))
            |-> (reg_a_o == win_q[15:12]) && (reg_b_o == win_q[11:8]));

    assert_branch_noregs_R4: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        (!illegal_o && icode_o == 4'h7) |-> (reg_a_o == 4'h8) && (reg_b_o == 4'h8));

    assert_short_noimm_R7: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        (len_o <= 3'd2) |-> (imm_o == '0));

    assert_pc_step_R8: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        pc_next_o == pc_q + ADDR_W'(len_o));

    assert_bad_forced_R10: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
        illegal_o |-> (len_o == 3'd1) && (reg_a_o == 4'h8) && (reg_b_o == 4'h8) && (imm_o == '0));

endmodule

bind vlx_decoder vlx_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .win_i     (win_i),
    .pc_i      (pc_i),
    .icode_o   (icode_o),
    .ifun_o    (ifun_o),
    .reg_a_o   (reg_a_o),
    .reg_b_o   (reg_b_o),
    .imm_o     (imm_o),
    .len_o     (len_o),
    .pc_next_o (pc_next_o),
    .illegal_o (illegal_o)
);

// File: tb/vlx_decoder_tb_top.sv
`timescale 1ns/1ps
module vlx_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] win = '0;
    logic [31:0] pc  = '0;
    logic [3:0]  icode, ifun, reg_a, reg_b;
    logic [31:0] imm, pc_next;
    logic [2:0]  len;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    vlx_decoder dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .win_i     (win),
        .pc_i      (pc),
        .icode_o   (icode),
        .ifun_o    (ifun),
        .reg_a_o   (reg_a),
        .reg_b_o   (reg_b),
        .imm_o     (imm),
        .len_o     (len),
        .pc_next_o (pc_next),
        .illegal_o (illegal)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected values, from the requirement tables
    logic [3:0]  e_a, e_b;
    logic [31:0] e_imm, e_pc;
    logic [2:0]  e_len;
    logic        e_bad;

    task automatic model(input logic [47:0] w, input logic [31:0] p);
        int c, f;
        c = int'(w[7:4]);
        f = int'(w[3:0]);
        e_bad = (c > 7) || (c == 6 && f > 3) || (c == 7 && f > 6) || (c <= 5 && f != 0);
        e_a = 4'h8;
        e_b = 4'h8;
        e_imm = 0;
        e_len = 3'd1;
        if (!e_bad) begin
            if (c == 2 || c == 6) e_len = 3'd2;
            if (c == 7) e_len = 3'd5;
            if (c >= 3 && c <= 5) e_len = 3'd6;
            if (c >= 2 && c <= 6) begin
                e_a = w[15:12];
                e_b = w[11:8];
            end
            if (c >= 3 && c <= 5)
                e_imm = w[47:40] * 32'h0100_0000 + w[39:32] * 32'h1_0000 + w[31:24] * 32'h100 + 32'(w[23:16]);
            if (c == 7)
                e_imm = w[39:32] * 32'h0100_0000 + w[31:24] * 32'h1_0000 + w[23:16] * 32'h100 + 32'(w[15:8]);
        end
        e_pc = p + 32'(e_len);
    endtask

    task automatic run_vec(input logic [47:0] w, input logic [31:0] p);
        string rr, ri;
        int c;
        @(negedge clk);
        win = w;
        pc  = p;
        model(w, p);
        @(posedge clk);
        #1;
        c  = int'(w[7:4]);
        rr = e_bad ? "R10" : ((c == 3) ? "R12" : ((c >= 2 && c <= 6) ? "R3" : "R4"));
        ri = e_bad ? "R10" : ((c >= 3 && c <= 5) ? "R5" : ((c == 7) ? "R6" : "R7"));
        chk("R1", "icode", 32'(icode), 32'(w[7:4]));
        chk("R1", "ifun", 32'(ifun), 32'(w[3:0]));
        chk("R9", "illegal", 32'(illegal), 32'(e_bad));
        chk(e_bad ? "R10" : "R2", "len", 32'(len), 32'(e_len));
        chk(rr, "reg_a", 32'(reg_a), 32'(e_a));
        chk(rr, "reg_b", 32'(reg_b), 32'(e_b));
        chk(ri, "imm", imm, e_imm);
        chk("R8", "pc_next", pc_next, e_pc);
    endtask

    initial begin
        // R11 reset state
        win = 48'h1122_3344_5530;
        pc  = 32'h0000_4000;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "rst icode", 32'(icode), 0);
        chk("R11", "rst reg_a", 32'(reg_a), 32'h8);
        chk("R11", "rst reg_b", 32'(reg_b), 32'h8);
        chk("R11", "rst imm", imm, 0);
        chk("R11", "rst len", 32'(len), 0);
        chk("R11", "rst pc_next", pc_next, 0);
        chk("R11", "rst illegal", 32'(illegal), 0);
        @(negedge clk);
        rst = 1'b0;

        // R5 worked example: load immediate with cd ab 00 00
        run_vec(48'h0000_abcd_8230, 32'h0000_0100);
        chk("R5", "example imm", imm, 32'h0000_abcd);

        // R11 latency: new input visible only after the next edge
        @(negedge clk);
        win = 48'h0000_0000_0010;
        #1;
        chk("R11", "hold imm", imm, 32'h0000_abcd);
        chk("R11", "hold len", 32'(len), 6);

        // sweep of every first byte under three tail patterns
        for (int pat = 0; pat < 3; pat++) begin
            for (int i = 0; i < 256; i++) begin
                logic [47:0] w;
                logic [31:0] p;
                for (int k = 1; k < 6; k++)
                    w[k*8 +: 8] = 8'((i * (17 + 2 * k) + pat * 91 + k * 29) & 8'hff);
                w[7:0] = 8'(i);
                if (pat == 2)      p = 32'hFFFF_FFFC;
                else if (pat == 1) p = 32'h8000_0000 + 32'(i * 13);
                else               p = 32'(i * 6);
                run_vec(w, p);
            end
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule